// File: doc/BRIEF.md
# Reloadable 12-bit Timer/Counter

This block is a 12-bit up-counter with two operating modes, selected by a control register. In timer mode it advances on a count-enable tick. When it steps past 0xFFF, it loads a value that software programmed earlier and keeps counting from there. That overflow raises a sticky interrupt flag when the interrupt-enable input is high, and it also pulses a wake-up output. In event mode it counts rising edges of an external input, which may be asynchronous. In this mode software clears or presets the count by writing the count registers.

Software reaches the block through a simple register port with address, write data, write enable, read enable and combinational read data. The 12-bit value is split across two addresses: a low byte at 0x14 and a high nibble at 0x1C. A read of the low byte captures the high nibble at the same time, so reading low then high gives a coherent 12-bit value even while the counter runs. Reads never disturb the count.

Top module: `tmr12_counter`

## Requirements
- R1: After reset, the count, the reload value, the run bit and the interrupt flag are zero, the mode is timer, and wake_o is low.
- R2: In timer mode with run set, every clock cycle with tick_i high adds one to the count. Cycles with tick_i low leave it unchanged.
- R3: In timer mode, a tick while the count is 0xFFF loads the reload value instead of 0x000. wake_o is high for exactly the one cycle that follows such an overflow.
- R4: An overflow sets the interrupt flag (irq_o) only if irq_en_i is high in that cycle. The flag stays set until software writes the control register with bit 2 = 1.
- R5: In timer mode with run set, a write to 0x14 (bits 7:0) or 0x1C (bits 3:0) changes only the reload value. The running count is not touched, and the new value is used at the next overflow.
- R6: In timer mode with run clear, a write to 0x14 or 0x1C loads that part of both the reload value and the count.
- R7: In event mode with run set, each rising edge of evt_i adds exactly one to the count, however long the level stays high, and tick_i has no effect. Stepping past 0xFFF wraps to 0x000 with no interrupt and no wake pulse.
- R8: In event mode, a write to 0x14 or 0x1C replaces that part of the count, so writing zero to both clears it.
- R9: Reading 0x14 returns count bits 7:0. A read-enabled access to 0x14 captures count bits 11:8, which later reads of 0x1C return in bits 3:0 with bits 7:4 zero. Reads never change the count.
- R10: The control register at 0x0F holds run in bit 0 and the mode in bit 1 (0 = timer, 1 = event); writing bit 2 = 1 clears the flag. A read returns run, mode and the flag in bits 0, 1 and 2.
- R11: With run clear, the count holds in both modes unless it is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 5 | Register address |
| wdata_i | input | 8 | Write data |
| we_i | input | 1 | Write enable |
| re_i | input | 1 | Read enable (captures high nibble on low-byte read) |
| rdata_o | output | 8 | Read data, combinational from addr_i |
| tick_i | input | 1 | Count-enable tick for timer mode |
| evt_i | input | 1 | External event input for event mode, asynchronous |
| irq_en_i | input | 1 | Interrupt enable for the overflow flag |
| irq_o | output | 1 | Sticky overflow interrupt flag |
| wake_o | output | 1 | One-cycle overflow pulse used as a wake-up source |

## Verification
The hardest cases to reach are overflows, because they happen only after the count climbs all the way to 0xFFF. Coherent reads are also awkward, since they need the high nibble to change between the two halves of a read. The bench preloads the count near the top while the timer is stopped, which makes the cycle between reload and 0xFFF short. It then sweeps sixteen cycle lengths against several tick counts, and predicts the final count, the flag and the number of wake pulses arithmetically. For coherence, the count is placed at 0x1FF in event mode, one edge arrives between the low and the high read, and the stale latched nibble is expected.

// File: rtl/tmr12_pkg.sv
package tmr12_pkg;
  typedef enum logic {
    MODE_TIMER = 1'b0,
    MODE_EVENT = 1'b1
  } tmr_mode_e;

  localparam int CTRL_RUN_BIT  = 0;
  localparam int CTRL_MODE_BIT = 1;
  localparam int CTRL_CLR_BIT  = 2;
endpackage

// File: rtl/tmr12_evt_edge.sv
module tmr12_evt_edge #(
  parameter int SYNC_W = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic evt_i,
  output logic rise_o
);
  logic [SYNC_W-1:0] sync_q;
  logic              prev_q;

  generate
    if (SYNC_W == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= evt_i;
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= {sync_q[SYNC_W-2:0], evt_i};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sync_q[SYNC_W-1];

  assign rise_o = sync_q[SYNC_W-1] & ~prev_q;
endmodule

// File: rtl/tmr12_core.sv
module tmr12_core
  import tmr12_pkg::*;
#(
  parameter int CNT_W = 12,
  parameter int LO_W  = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  run_i,
  input  tmr_mode_e             mode_i,
  input  logic                  tick_i,
  input  logic                  evt_rise_i,
  input  logic                  wr_lo_i,
  input  logic                  wr_hi_i,
  input  logic [LO_W-1:0]       wdata_lo_i,
  input  logic [CNT_W-LO_W-1:0] wdata_hi_i,
  output logic [CNT_W-1:0]      cnt_o,
  output logic [CNT_W-1:0]      reload_o,
  output logic                  ovf_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d, reload_q, reload_d;
  logic step, at_max, load_cnt;

  assign step     = run_i & ((mode_i == MODE_TIMER) ? tick_i : evt_rise_i);
  assign at_max   = &cnt_q;
  assign ovf_o    = step & at_max & (mode_i == MODE_TIMER);
  // count registers address the count itself when not a running timer
  assign load_cnt = (mode_i == MODE_EVENT) | ~run_i;

  always_comb begin
    reload_d = reload_q;
    if (mode_i == MODE_TIMER) begin
      if (wr_lo_i) reload_d[LO_W-1:0]     = wdata_lo_i;
      if (wr_hi_i) reload_d[CNT_W-1:LO_W] = wdata_hi_i;
    end
    cnt_d = cnt_q;
    if (load_cnt && (wr_lo_i || wr_hi_i)) begin
      if (wr_lo_i) cnt_d[LO_W-1:0]     = wdata_lo_i;
      if (wr_hi_i) cnt_d[CNT_W-1:LO_W] = wdata_hi_i;
    end else if (step) begin
      cnt_d = ovf_o ? reload_d : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      cnt_q    <= '0;
      reload_q <= '0;
    end else begin
      cnt_q    <= cnt_d;
      reload_q <= reload_d;
    end

  assign cnt_o    = cnt_q;
  assign reload_o = reload_q;
endmodule

// File: rtl/tmr12_rd_port.sv
module tmr12_rd_port #(
  parameter int                CNT_W     = 12,
  parameter int                DW        = 8,
  parameter int                ADDR_W    = 5,
  parameter logic [ADDR_W-1:0] LO_ADDR   = 5'h14,
  parameter logic [ADDR_W-1:0] HI_ADDR   = 5'h1C,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 5'h0F
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [DW-1:0]     ctrl_i,
  output logic [DW-1:0]     rdata_o
);
  localparam int HI_W = CNT_W - DW;

  logic [HI_W-1:0] hi_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                          hi_q <= '0;
    else if (re_i && addr_i == LO_ADDR)   hi_q <= cnt_i[CNT_W-1:DW];

  always_comb begin
    rdata_o = '0;
    if (addr_i == LO_ADDR)        rdata_o = cnt_i[DW-1:0];
    else if (addr_i == HI_ADDR)   rdata_o[HI_W-1:0] = hi_q;
    else if (addr_i == CTRL_ADDR) rdata_o = ctrl_i;
  end
endmodule

// File: rtl/tmr12_counter.sv
module tmr12_counter
  import tmr12_pkg::*;
#(
  parameter int                CNT_W     = 12,
  parameter int                DW        = 8,
  parameter int                ADDR_W    = 5,
  parameter int                SYNC_W    = 2,
  parameter logic [ADDR_W-1:0] LO_ADDR   = 5'h14,
  parameter logic [ADDR_W-1:0] HI_ADDR   = 5'h1C,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 5'h0F
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic              we_i,
  input  logic              re_i,
  output logic [DW-1:0]     rdata_o,
  input  logic              tick_i,
  input  logic              evt_i,
  input  logic              irq_en_i,
  output logic              irq_o,
  output logic              wake_o
);
  localparam int HI_W = CNT_W - DW;

  logic             run_q, flag_q, wake_q;
  tmr_mode_e        mode_q;
  logic             evt_rise, ovf, ctrl_wr, wr_lo, wr_hi;
  logic [CNT_W-1:0] cnt_q, reload_q;
  logic [DW-1:0]    ctrl_rd;

  assign ctrl_wr = we_i && addr_i == CTRL_ADDR;
  assign wr_lo   = we_i && addr_i == LO_ADDR;
  assign wr_hi   = we_i && addr_i == HI_ADDR;

  tmr12_evt_edge #(.SYNC_W(SYNC_W)) u_evt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .evt_i  (evt_i),
    .rise_o (evt_rise)
  );

  tmr12_core #(.CNT_W(CNT_W), .LO_W(DW)) u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (run_q),
    .mode_i     (mode_q),
    .tick_i     (tick_i),
    .evt_rise_i (evt_rise),
    .wr_lo_i    (wr_lo),
    .wr_hi_i    (wr_hi),
    .wdata_lo_i (wdata_i),
    .wdata_hi_i (wdata_i[HI_W-1:0]),
    .cnt_o      (cnt_q),
    .reload_o   (reload_q),
    .ovf_o      (ovf)
  );

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      run_q  <= 1'b0;
      mode_q <= MODE_TIMER;
    end else if (ctrl_wr) begin
      run_q  <= wdata_i[CTRL_RUN_BIT];
      mode_q <= tmr_mode_e'(wdata_i[CTRL_MODE_BIT]);
    end

  // set wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                               flag_q <= 1'b0;
    else if (ovf && irq_en_i)                  flag_q <= 1'b1;
    else if (ctrl_wr && wdata_i[CTRL_CLR_BIT]) flag_q <= 1'b0;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) wake_q <= 1'b0;
    else         wake_q <= ovf;

  always_comb begin
    ctrl_rd                = '0;
    ctrl_rd[CTRL_RUN_BIT]  = run_q;
    ctrl_rd[CTRL_MODE_BIT] = mode_q;
    ctrl_rd[CTRL_CLR_BIT]  = flag_q;
  end

  tmr12_rd_port #(
    .CNT_W(CNT_W), .DW(DW), .ADDR_W(ADDR_W),
    .LO_ADDR(LO_ADDR), .HI_ADDR(HI_ADDR), .CTRL_ADDR(CTRL_ADDR)
  ) u_rd (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .re_i    (re_i),
    .addr_i  (addr_i),
    .cnt_i   (cnt_q),
    .ctrl_i  (ctrl_rd),
    .rdata_o (rdata_o)
  );

  assign irq_o  = flag_q;
  assign wake_o = wake_q;
endmodule

// File: rtl/tmr12_counter_chk.sv
module tmr12_counter_chk #(
  parameter int CNT_W = 12
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             we_i,
  input logic             tick_i,
  input logic             irq_en_i,
  input logic             irq_o,
  input logic             wake_o,
  input logic             run,
  input logic             mode,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] reload,
  input logic             ovf
);
  a_r2_tick_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && !mode && tick_i && !(&cnt) && !we_i) |=> cnt == CNT_W'($past(cnt) + 1'b1));

  a_r3_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf && !we_i) |=> cnt == $past(reload));

  a_r3_wake_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> $past(ovf));

  a_r4_irq_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf && irq_en_i) |=> irq_o);

  a_r4_irq_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_o && !(ovf && irq_en_i)) |=> !irq_o);

  a_r11_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run && !we_i) |=> $stable(cnt));
endmodule

bind tmr12_counter tmr12_counter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .we_i     (we_i),
  .tick_i   (tick_i),
  .irq_en_i (irq_en_i),
  .irq_o    (irq_o),
  .wake_o   (wake_o),
  .run      (run_q),
  .mode     (mode_q),
  .cnt      (cnt_q),
  .reload   (reload_q),
  .ovf      (ovf)
);

// File: tb/tmr12_counter_test.sv
`timescale 1ns/1ps
module tmr12_counter_test;
  localparam logic [4:0] A_LO = 5'h14, A_HI = 5'h1C, A_CTRL = 5'h0F;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic [4:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       we = 1'b0, re = 1'b0, tick = 1'b0, evt = 1'b0, ie = 1'b0;
  logic [7:0] rdata;
  logic       irq, wake;

  int n_run = 0, n_fail = 0, wake_cnt = 0;
  bit done = 0;

  tmr12_counter uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata), .we_i(we),
    .re_i(re), .rdata_o(rdata), .tick_i(tick), .evt_i(evt),
    .irq_en_i(ie), .irq_o(irq), .wake_o(wake)
  );

  always #2.5 clk = ~clk;

  always @(negedge clk) if (wake) wake_cnt++;

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; re = 1'b1; #1 d = rdata;
    @(negedge clk); re = 1'b0;
  endtask

  task automatic rd12(output int v);
    logic [7:0] lo, hi;
    rd(A_LO, lo); rd(A_HI, hi);
    v = {hi[3:0], lo};
  endtask

  task automatic ticks(input int n);
    @(negedge clk); tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic evt_pulse(input int hold);
    @(negedge clk); evt = 1'b1;
    repeat (hold) @(negedge clk);
    evt = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic summary;
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int v, w0;
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd12(v); chk("R1 count", v, 0);
    rd(A_CTRL, d); chk("R1 ctrl", d, 0);
    chk("R1 irq", irq, 0); chk("R1 wake", wake, 0);

    // R2 R3 R4 R6 sweep of cycle lengths
    ie = 1'b1;
    for (int k = 0; k < 16; k++) begin
      int r, p, n;
      r = 12'hFFF - k; p = k + 1; n = 2 * k + 3;
      wr(A_CTRL, 8'h04);
      wr(A_LO, r[7:0]); wr(A_HI, {4'h0, r[11:8]});
      rd12(v); chk("R6 stopped load", v, r);
      w0 = wake_cnt;
      wr(A_CTRL, 8'h01);
      ticks(n);
      wr(A_CTRL, 8'h00);
      rd12(v); chk("R2/R3 count after ticks", v, r + (n % p));
      chk("R4 flag", irq, (n >= p) ? 1 : 0);
      chk("R3 wake pulses", wake_cnt - w0, n / p);
    end

    // R11 stopped timer ignores ticks
    ticks(10); rd12(v); chk("R11 stopped hold", v, 12'hFF0 + (33 % 16));

    // R4 no flag with irq_en low; R10 clear
    wr(A_CTRL, 8'h04); chk("R10 clear flag", irq, 0);
    ie = 1'b0;
    wr(A_LO, 8'hFE); wr(A_HI, 8'h0F);
    wr(A_CTRL, 8'h01); ticks(3);
    chk("R4 no flag when disabled", irq, 0);
    ie = 1'b1; ticks(2);
    chk("R4 flag when enabled", irq, 1);
    ticks(5); chk("R4 flag sticky", irq, 1);
    rd(A_CTRL, d); chk("R10 ctrl readback", d, 8'h05);
    wr(A_CTRL, 8'h05); chk("R4 flag cleared", irq, 0);

    // R5 reload write while running
    wr(A_CTRL, 8'h00);
    wr(A_LO, 8'hFD); wr(A_HI, 8'h0F);
    wr(A_CTRL, 8'h01);
    wr(A_LO, 8'h00); wr(A_HI, 8'h01);
    rd12(v); chk("R5 count untouched", v, 12'hFFD);
    ticks(3);
    wr(A_CTRL, 8'h00);
    rd12(v); chk("R5 new reload used", v, 12'h100);

    // R7 R8 event mode, ticks ignored
    wr(A_CTRL, 8'h07);
    rd(A_CTRL, d); chk("R10 ctrl event mode", d, 8'h03);
    wr(A_LO, 8'h34); wr(A_HI, 8'h02);
    rd12(v); chk("R8 event load", v, 12'h234);
    wr(A_LO, 8'h00); wr(A_HI, 8'h00);
    rd12(v); chk("R8 cleared", v, 0);
    tick = 1'b1;
    for (int i = 1; i <= 5; i++) begin
      evt_pulse(i * 3);
      rd12(v); chk("R7 one per edge", v, i);
    end
    tick = 1'b0;
    wr(A_LO, 8'hFF); wr(A_HI, 8'h0F);
    w0 = wake_cnt;
    evt_pulse(2);
    rd12(v); chk("R7 wrap", v, 0);
    chk("R7 no irq", irq, 0); chk("R7 no wake", wake_cnt - w0, 0);

    // R9 coherent read
    wr(A_LO, 8'hFF); wr(A_HI, 8'h01);
    rd(A_LO, d); chk("R9 low", d, 8'hFF);
    evt_pulse(2);
    rd(A_HI, d); chk("R9 latched high", d, 8'h01);
    rd(A_HI, d); chk("R9 reread", d, 8'h01);
    rd12(v); chk("R9 fresh", v, 12'h200);

    // R11 stopped event mode
    wr(A_CTRL, 8'h02);
    evt_pulse(2);
    rd12(v); chk("R11 event stopped", v, 12'h200);

    summary();
  end
endmodule